// File: doc/BRIEF.md
# Linked Context Breakpoint Comparator

This block answers one question for a debug unit: does the breakpoint slot named by a link index hold a context-ID comparison that the current execution context satisfies? A watchpoint or an address breakpoint that is chained to a context slot passes this index in. The block then returns a single match bit that qualifies the parent's own hit.

The block receives the control and value registers of every breakpoint slot as flat vectors. Only the highest `N_CTX` slots can hold context comparisons. The block rejects any link outside that window, and any link whose target slot is disabled. It decodes a 4-bit type field in the target's control word, which selects which context-ID register takes part in the comparison. For the exception-level-dependent type, it also uses the current exception level and two hypervisor control bits. The chosen register is compared for full 32-bit equality with the low word of the slot's value register. The result is registered once, so it appears one clock after the inputs.

Top module: `ctx_link_match`

## Requirements
- R1: A link index greater than or equal to `N_SLOTS` gives `hit` = 0.
- R2: A link index below `N_SLOTS - N_CTX` gives `hit` = 0, even when that slot is otherwise a valid matching context entry.
- R3: Control bit 0 of the linked slot is its enable. When it is 0, `hit` = 0.
- R4: Control bits [23:20] hold the type. For type 3 at level 1 (`cur_el` = 1), the comparison uses `ctx_el1`.
- R5: For type 3 at level 2, `hit` is 0 when `hyp_e2h` = 0. When `hyp_e2h` = 1, the comparison uses `ctx_el2`.
- R6: For type 3 at level 3, `hit` is always 0.
- R7: For type 3 at level 0, the comparison uses `ctx_el2` when `hyp_e2h` and `hyp_tge` are both 1. Otherwise it uses `ctx_el1`.
- R8: Type 7 compares against `ctx_el1` at every exception level, whatever the hypervisor bits are.
- R9: Type 13 compares against `ctx_el2` at every exception level, whatever the hypervisor bits are.
- R10: Every other type value, including 9, 11 and 15, gives `hit` = 0.
- R11: The match requires all 32 bits of the chosen context register to equal value bits [31:0] of the linked slot. Value bits above 31 are ignored.
- R12: `hit` is 0 during reset. After reset it reflects the inputs of the previous clock edge, with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_idx | input | IDX_W | Index of the linked breakpoint slot |
| ctrl_flat | input | N_SLOTS*CTRL_W | Control registers of all slots, slot 0 in the low bits |
| val_flat | input | N_SLOTS*VAL_W | Value registers of all slots, slot 0 in the low bits |
| cur_el | input | 2 | Current exception level, 0 to 3 |
| hyp_e2h | input | 1 | Hypervisor host-extension control bit |
| hyp_tge | input | 1 | Hypervisor trap-general-exceptions control bit |
| ctx_el1 | input | 32 | Level-1 context identifier |
| ctx_el2 | input | 32 | Level-2 context identifier |
| hit | output | 1 | Registered match result |

## Verification
The only state in the block is the output flop, so every internal fault shows at `hit` on the clock edge right after the offending inputs are applied. A wrong slot selection or a wrong context-register selection shows up as a false hit or a missed hit. It is exposed by giving the two context registers different values, and by loading decoy slots that would match if the wrong one were read. Faults in the window boundaries, the enable bit or the type decode show as spurious ones in the cases that must never match. The bench therefore drives those cases with every other condition set to match.

// File: rtl/ctx_link_match.sv
module ctx_link_match #(
  parameter int N_SLOTS = 6,
  parameter int N_CTX   = 2,
  parameter int IDX_W   = 4,
  parameter int CTRL_W  = 64,
  parameter int VAL_W   = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           link_idx,
  input  logic [N_SLOTS*CTRL_W-1:0]  ctrl_flat,
  input  logic [N_SLOTS*VAL_W-1:0]   val_flat,
  input  logic [1:0]                 cur_el,
  input  logic                       hyp_e2h,
  input  logic                       hyp_tge,
  input  logic [31:0]                ctx_el1,
  input  logic [31:0]                ctx_el2,
  output logic                       hit
);

  localparam int CTX_BASE = N_SLOTS - N_CTX;
  localparam logic [3:0] TY_BY_EL = 4'd3;
  localparam logic [3:0] TY_EL1   = 4'd7;
  localparam logic [3:0] TY_EL2   = 4'd13;

  logic        sel_en;
  logic [3:0]  sel_ty;
  logic [31:0] sel_val;
  logic        in_window;
  logic        use_el1, use_el2;
  logic [31:0] chosen;
  logic        hit_d;
  logic        unused_bits;

  assign unused_bits = ^{ctrl_flat, val_flat};

  always_comb begin
    sel_en  = 1'b0;
    sel_ty  = 4'd0;
    sel_val = 32'd0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (i == int'(link_idx)) begin
        sel_en  = ctrl_flat[i*CTRL_W];
        sel_ty  = ctrl_flat[i*CTRL_W+20 +: 4];
        sel_val = val_flat[i*VAL_W +: 32];
      end
    end
  end

  assign in_window = (int'(link_idx) < N_SLOTS) && (int'(link_idx) >= CTX_BASE);

  always_comb begin
    use_el1 = 1'b0;
    use_el2 = 1'b0;
    case (sel_ty)
      TY_BY_EL: begin
        case (cur_el)
          2'd0: begin
            if (hyp_e2h && hyp_tge) use_el2 = 1'b1;
            else                    use_el1 = 1'b1;
          end
          2'd1: use_el1 = 1'b1;
          2'd2: use_el2 = hyp_e2h;
          default: ;
        endcase
      end
      TY_EL1:  use_el1 = 1'b1;
      TY_EL2:  use_el2 = 1'b1;
      default: ;
    endcase
  end

  assign chosen = use_el2 ? ctx_el2 : ctx_el1;
  assign hit_d  = in_window && sel_en && (use_el1 || use_el2) && (chosen == sel_val);

  always_ff @(posedge clk) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= hit_d;
  end

  AST_IDX_TOO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(link_idx) >= N_SLOTS) |=> !hit); // R1
  AST_IDX_TOO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(link_idx) < CTX_BASE) |=> !hit); // R2
  AST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_en |=> !hit); // R3
  AST_EL2_NEEDS_E2H: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ty == TY_BY_EL && cur_el == 2'd2 && !hyp_e2h) |=> !hit); // R5
  AST_EL3_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ty == TY_BY_EL && cur_el == 2'd3) |=> !hit); // R6
  AST_RESERVED_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ty != TY_BY_EL && sel_ty != TY_EL1 && sel_ty != TY_EL2) |=> !hit); // R10
  AST_LOW_WORD_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_el1 == ctx_el2 && ctx_el1 != sel_val) |=> !hit); // R11

endmodule

// File: tb/test_ctx_link_match.sv
module test_ctx_link_match;
  localparam int NS = 6;
  localparam int NC = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [3:0]       link_idx = '0;
  logic [NS-1:0][63:0] ctrl_p = '0;
  logic [NS-1:0][63:0] val_p = '0;
  logic [1:0]       cur_el = '0;
  logic             hyp_e2h = 1'b0;
  logic             hyp_tge = 1'b0;
  logic [31:0]      ctx_el1 = 32'h1111_AAAA;
  logic [31:0]      ctx_el2 = 32'h2222_BBBB;
  logic             hit;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ctx_link_match #(.N_SLOTS(NS), .N_CTX(NC), .IDX_W(4), .CTRL_W(64), .VAL_W(64)) i_ctx_link_match (
    .clk(clk), .rst_n(rst_n), .link_idx(link_idx), .ctrl_flat(ctrl_p), .val_flat(val_p),
    .cur_el(cur_el), .hyp_e2h(hyp_e2h), .hyp_tge(hyp_tge),
    .ctx_el1(ctx_el1), .ctx_el2(ctx_el2), .hit(hit));

  function automatic logic [63:0] mk_ctrl(input logic [3:0] ty, input logic en);
    return {40'hFFFF_0000_00, ty, 19'h0_5A5A, en};
  endfunction

  task automatic chk(input logic exp, input string tag);
    total++;
    if (hit !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, hit, exp);
    end
  endtask

  task automatic drive(input int idx, input logic [1:0] el, input logic e2h, input logic tge);
    @(negedge clk);
    link_idx = 4'(idx); cur_el = el; hyp_e2h = e2h; hyp_tge = tge;
    @(posedge clk); #1;
  endtask

  task automatic load_all(input logic [3:0] ty, input logic [31:0] v);
    @(negedge clk);
    for (int i = 0; i < NS; i++) begin
      ctrl_p[i] = mk_ctrl(ty, 1'b1);
      val_p[i]  = {32'hDEAD_0000, v};
    end
  endtask

  task automatic t_reset();
    chk(1'b0, "R12 reset value");
    load_all(4'd7, ctx_el1);
    link_idx = 4'd5; cur_el = 2'd1;
    @(posedge clk); #1;
    chk(1'b0, "R12 held in reset");
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_latency();
    load_all(4'd7, ctx_el1);
    drive(0, 2'd1, 1'b0, 1'b0);
    chk(1'b0, "R12 setup idle");
    @(negedge clk); link_idx = 4'd5; #1;
    chk(1'b0, "R12 no combinational path");
    @(posedge clk); #1;
    chk(1'b1, "R12 one cycle later");
  endtask

  task automatic t_range();
    load_all(4'd7, ctx_el1);
    drive(6, 2'd1, 1'b0, 1'b0);  chk(1'b0, "R1 idx 6");
    drive(7, 2'd1, 1'b0, 1'b0);  chk(1'b0, "R1 idx 7");
    drive(15, 2'd1, 1'b0, 1'b0); chk(1'b0, "R1 idx 15");
    for (int i = 0; i < NS - NC; i++) begin
      drive(i, 2'd1, 1'b0, 1'b0); chk(1'b0, $sformatf("R2 idx %0d", i));
    end
    drive(4, 2'd1, 1'b0, 1'b0); chk(1'b1, "R2 lowest context slot");
  endtask

  task automatic t_enable();
    load_all(4'd7, ctx_el1);
    ctrl_p[5] = mk_ctrl(4'd7, 1'b0);
    drive(5, 2'd1, 1'b0, 1'b0); chk(1'b0, "R3 disabled");
    ctrl_p[5] = mk_ctrl(4'd7, 1'b1);
    drive(5, 2'd1, 1'b0, 1'b0); chk(1'b1, "R3 enabled");
  endtask

  task automatic t_by_level();
    load_all(4'd3, ctx_el1);
    val_p[4] = {32'h0, ctx_el2};
    drive(5, 2'd1, 1'b1, 1'b1); chk(1'b1, "R4 el1 uses ctx_el1");
    drive(4, 2'd1, 1'b1, 1'b1); chk(1'b0, "R4 el1 ignores ctx_el2");
    drive(4, 2'd2, 1'b0, 1'b0); chk(1'b0, "R5 el2 without e2h");
    drive(4, 2'd2, 1'b1, 1'b0); chk(1'b1, "R5 el2 with e2h");
    drive(5, 2'd2, 1'b1, 1'b0); chk(1'b0, "R5 el2 ignores ctx_el1");
    drive(4, 2'd0, 1'b1, 1'b1); chk(1'b1, "R7 el0 e2h tge ctx_el2");
    drive(5, 2'd0, 1'b1, 1'b1); chk(1'b0, "R7 el0 e2h tge not ctx_el1");
    drive(5, 2'd0, 1'b1, 1'b0); chk(1'b1, "R7 el0 e2h only ctx_el1");
    drive(5, 2'd0, 1'b0, 1'b1); chk(1'b1, "R7 el0 tge only ctx_el1");
    drive(4, 2'd0, 1'b0, 1'b1); chk(1'b0, "R7 el0 tge only not ctx_el2");
    @(negedge clk); ctx_el2 = ctx_el1;
    for (int m = 0; m < 4; m++) begin
      drive(5, 2'd3, m[0], m[1]); chk(1'b0, $sformatf("R6 el3 e2h=%0d tge=%0d", m[0], m[1]));
    end
    @(negedge clk); ctx_el2 = 32'h2222_BBBB;
  endtask

  task automatic t_fixed();
    load_all(4'd7, ctx_el1);
    ctrl_p[4] = mk_ctrl(4'd13, 1'b1);
    val_p[4]  = {32'h0, ctx_el2};
    for (int el = 0; el < 4; el++) begin
      drive(5, 2'(el), 1'b0, 1'b0); chk(1'b1, $sformatf("R8 type7 el%0d", el));
      drive(4, 2'(el), 1'b1, 1'b1); chk(1'b1, $sformatf("R9 type13 el%0d", el));
    end
    val_p[5] = {32'h0, ctx_el2};
    drive(5, 2'd2, 1'b1, 1'b1); chk(1'b0, "R8 type7 ignores ctx_el2");
  endtask

  task automatic t_reserved();
    @(negedge clk); ctx_el2 = ctx_el1;
    for (int ty = 0; ty < 16; ty++) begin
      if (ty != 3 && ty != 7 && ty != 13) begin
        load_all(4'(ty), ctx_el1);
        drive(5, 2'd1, 1'b1, 1'b0); chk(1'b0, $sformatf("R10 type %0d", ty));
      end
    end
    @(negedge clk); ctx_el2 = 32'h2222_BBBB;
  endtask

  task automatic t_compare();
    load_all(4'd7, ctx_el1);
    val_p[5] = {32'hFFFF_FFFF, ctx_el1};
    drive(5, 2'd1, 1'b0, 1'b0); chk(1'b1, "R11 upper bits ignored");
    val_p[5] = {32'h0, ctx_el1 ^ 32'h8000_0000};
    drive(5, 2'd1, 1'b0, 1'b0); chk(1'b0, "R11 bit 31 differs");
    val_p[5] = {32'h0, ctx_el1 ^ 32'h0000_0001};
    drive(5, 2'd1, 1'b0, 1'b0); chk(1'b0, "R11 bit 0 differs");
  endtask

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_latency();
    t_range();
    t_enable();
    t_by_level();
    t_fixed();
    t_reserved();
    t_compare();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule